// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits on the I/O side of a host bridge. It watches processor I/O cycles and claims two dword locations: a 32-bit address register at I/O port 0CF8h and a 32-bit data window at 0CFCh through 0CFFh. Software writes a bus, device, function and dword register number, plus an enable bit, into the address register. It then reads or writes the data window, and the block turns that access into one configuration request. The request carries the routing fields and the byte lanes of the access. The target side answers through a request/acknowledge handshake.

The I/O side uses a dword address with four byte enables. A request is held until the block pulses `ioReady` for one cycle. The block pulses `ioHit` with `ioReady` when it claims the access. An unclaimed access completes with `ioHit` low and read data of all ones, and it changes nothing. While the enable bit is clear, the data window is not claimed. It then behaves like any other unclaimed I/O location.

Top module: `cfg_port`

## Requirements
- R1: After reset the address register is zero, so mapping is disabled. `cfgReq` and `ioReady` are low, and a full read of dword 0CF8h returns 0.
- R2: A full write (all four byte enables) to dword 0CF8h is claimed. It stores bit 31 (enable), bits 23:16 (bus), 15:11 (device), 10:8 (function) and 7:2 (dword register number). A full read of that dword is claimed and returns the stored value, with bits 30:24 and 1:0 always zero.
- R3: An access to dword 0CF8h with fewer than four byte enables is not claimed. A read returns 32'hFFFF_FFFF, and a write leaves the address register unchanged.
- R4: With bit 31 set, an access to dword 0CFCh that has at least one byte enable issues exactly one configuration request. The request carries bus, device, function and register number from the address register, `ioBe` as `cfgBe`, the write direction, and the write data. All of these stay stable while `cfgReq` is high.
- R5: With bit 31 clear, an access to dword 0CFCh issues no configuration request and is not claimed. A read returns all ones.
- R6: `cfgReq` stays high until the cycle in which `cfgAck` is sampled high, and it is low in the next cycle. `ioReady` is withheld until then and rises in the cycle after the acknowledge, which gives an access latency of 2 + (ack wait) cycles.
- R7: A claimed data-window read completes with `ioHit` high and `ioRdata` equal to the `cfgRdata` sampled with `cfgAck`.
- R8: Accesses that need no configuration request complete with `ioReady` one cycle after acceptance. `ioReady` is always a single-cycle pulse, and `ioHit` is high only together with `ioReady`.
- R9: Accesses to any other dword address are not claimed, return all ones and issue no configuration request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioReq | input | 1 | I/O access pending; held until ioReady |
| ioWrite | input | 1 | 1 = write, 0 = read |
| ioDwAddr | input | IO_AW-2 | I/O dword address (byte address >> 2) |
| ioBe | input | 4 | Byte enables of the dword |
| ioWdata | input | 32 | Write data |
| ioRdata | output | 32 | Read data, valid with ioReady |
| ioReady | output | 1 | One-cycle completion pulse |
| ioHit | output | 1 | Access was claimed, valid with ioReady |
| cfgReq | output | 1 | Configuration request pending |
| cfgWrite | output | 1 | Configuration write when 1 |
| cfgBus | output | 8 | Target bus number |
| cfgDev | output | 5 | Target device number |
| cfgFunc | output | 3 | Target function |
| cfgReg | output | 6 | Dword register number |
| cfgBe | output | 4 | Byte lanes of the configuration access |
| cfgWdata | output | 32 | Configuration write data |
| cfgAck | input | 1 | Target completion, sampled while cfgReq is high |
| cfgRdata | input | 32 | Target read data, sampled with cfgAck |

## Verification
A corrupted address register first shows up on the next read of 0CF8h. It also shows up in the routing fields of the next configuration request, which are compared against a bench model in every cycle that `cfgReq` is high. A wrong enable bit shows within a single access: either a request appears where none should, or an all-ones unclaimed read appears where the response data was expected. A control state that is stuck or skipped shows as a latency that differs from 1 or 2 + wait cycles, or as an `ioReady` that lasts longer than one cycle. Either of these is caught on that same access.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int REG_W  = 6;

  // Source of the captured completion data
  typedef enum logic [1:0] {RD_ZERO, RD_ONES, RD_ADDR, RD_RSP} rdSrc_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   loadAddr;   // store address register from ioWdata
    logic   latchReq;   // latch direction, lanes and data of a window access
    logic   capRd;      // capture completion data and hit flag
    rdSrc_t rdSrc;
    logic   hit;
  } dpStrobe_t;
endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int DW_AW = 14,
  parameter logic [DW_AW-1:0] ADDR_DW = 14'h33E,
  parameter logic [DW_AW-1:0] DATA_DW = 14'h33F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ioReq,
  input  logic             ioWrite,
  input  logic [DW_AW-1:0] ioDwAddr,
  input  logic [3:0]       ioBe,
  input  logic             mapEn,
  input  logic             cfgAck,
  output dpStrobe_t        strb,
  output logic             cfgReq,
  output logic             ioReady
);
  typedef enum logic [1:0] {S_IDLE, S_CFG, S_DONE} state_t;
  state_t state, stateNxt;

  logic isAddr, isData, fullDw, anyBe;
  assign isAddr = (ioDwAddr == ADDR_DW);
  assign isData = (ioDwAddr == DATA_DW);
  assign fullDw = (ioBe == 4'hF);
  assign anyBe  = |ioBe;

  always_comb begin
    stateNxt = state;
    strb     = '{loadAddr: 1'b0, latchReq: 1'b0, capRd: 1'b0, rdSrc: RD_ONES, hit: 1'b0};
    unique case (state)
      S_IDLE: if (ioReq) begin
        if (isAddr && fullDw) begin
          strb.capRd    = 1'b1;
          strb.hit      = 1'b1;
          strb.loadAddr = ioWrite;
          strb.rdSrc    = ioWrite ? RD_ZERO : RD_ADDR;
          stateNxt      = S_DONE;
        end else if (isData && mapEn && anyBe) begin
          strb.latchReq = 1'b1;
          stateNxt      = S_CFG;
        end else begin
          strb.capRd = 1'b1;
          strb.rdSrc = RD_ONES;
          stateNxt   = S_DONE;
        end
      end
      S_CFG: if (cfgAck) begin
        strb.capRd = 1'b1;
        strb.hit   = 1'b1;
        strb.rdSrc = RD_RSP;
        stateNxt   = S_DONE;
      end
      S_DONE:  stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign cfgReq  = (state == S_CFG);
  assign ioReady = (state == S_DONE);
endmodule

// File: rtl/cfg_port_dp.sv
module cfg_port_dp
  import cfg_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              ioWrite,
  input  logic [3:0]        ioBe,
  input  logic [31:0]       ioWdata,
  input  logic [31:0]       cfgRdata,
  output logic              mapEn,
  output logic [BUS_W-1:0]  cfgBus,
  output logic [DEV_W-1:0]  cfgDev,
  output logic [FUNC_W-1:0] cfgFunc,
  output logic [REG_W-1:0]  cfgReg,
  output logic              cfgWrite,
  output logic [3:0]        cfgBe,
  output logic [31:0]       cfgWdata,
  output logic [31:0]       ioRdata,
  output logic              hitQ
);
  // Only the meaningful fields are stored; reserved bits do not exist.
  logic              mapQ;
  logic [BUS_W-1:0]  busQ;
  logic [DEV_W-1:0]  devQ;
  logic [FUNC_W-1:0] funcQ;
  logic [REG_W-1:0]  regQ;
  logic [31:0]       addrView;

  assign addrView = {mapQ, 7'b0, busQ, devQ, funcQ, regQ, 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mapQ <= 1'b0; busQ <= '0; devQ <= '0; funcQ <= '0; regQ <= '0;
      cfgWrite <= 1'b0; cfgBe <= '0; cfgWdata <= '0;
      ioRdata <= '0; hitQ <= 1'b0;
    end else begin
      if (strb.loadAddr) begin
        mapQ  <= ioWdata[31];
        busQ  <= ioWdata[23:16];
        devQ  <= ioWdata[15:11];
        funcQ <= ioWdata[10:8];
        regQ  <= ioWdata[7:2];
      end
      if (strb.latchReq) begin
        cfgWrite <= ioWrite;
        cfgBe    <= ioBe;
        cfgWdata <= ioWdata;
      end
      if (strb.capRd) begin
        hitQ <= strb.hit;
        unique case (strb.rdSrc)
          RD_ZERO: ioRdata <= '0;
          RD_ONES: ioRdata <= '1;
          RD_ADDR: ioRdata <= addrView;
          RD_RSP:  ioRdata <= cfgRdata;
          default: ioRdata <= '1;
        endcase
      end
    end
  end

  assign mapEn   = mapQ;
  assign cfgBus  = busQ;
  assign cfgDev  = devQ;
  assign cfgFunc = funcQ;
  assign cfgReg  = regQ;
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioReq,
  input  logic              ioWrite,
  input  logic [IO_AW-3:0]  ioDwAddr,
  input  logic [3:0]        ioBe,
  input  logic [31:0]       ioWdata,
  output logic [31:0]       ioRdata,
  output logic              ioReady,
  output logic              ioHit,
  output logic              cfgReq,
  output logic              cfgWrite,
  output logic [BUS_W-1:0]  cfgBus,
  output logic [DEV_W-1:0]  cfgDev,
  output logic [FUNC_W-1:0] cfgFunc,
  output logic [REG_W-1:0]  cfgReg,
  output logic [3:0]        cfgBe,
  output logic [31:0]       cfgWdata,
  input  logic              cfgAck,
  input  logic [31:0]       cfgRdata
);
  localparam int DW_AW = IO_AW - 2;
  localparam logic [DW_AW-1:0] ADDR_DW = ADDR_PORT[IO_AW-1:2];
  localparam logic [DW_AW-1:0] DATA_DW = DATA_PORT[IO_AW-1:2];

  dpStrobe_t strb;
  logic      mapEn;
  logic      hitQ;

  cfg_port_ctrl #(.DW_AW(DW_AW), .ADDR_DW(ADDR_DW), .DATA_DW(DATA_DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioReq(ioReq), .ioWrite(ioWrite), .ioDwAddr(ioDwAddr),
    .ioBe(ioBe), .mapEn(mapEn), .cfgAck(cfgAck), .strb(strb),
    .cfgReq(cfgReq), .ioReady(ioReady)
  );

  cfg_port_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWrite(ioWrite), .ioBe(ioBe),
    .ioWdata(ioWdata), .cfgRdata(cfgRdata), .mapEn(mapEn), .cfgBus(cfgBus),
    .cfgDev(cfgDev), .cfgFunc(cfgFunc), .cfgReg(cfgReg), .cfgWrite(cfgWrite),
    .cfgBe(cfgBe), .cfgWdata(cfgWdata), .ioRdata(ioRdata), .hitQ(hitQ)
  );

  assign ioHit = hitQ & ioReady;
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int DW_AW = 14,
  parameter logic [DW_AW-1:0] DATA_DW = 14'h33F
) (
  input logic             clk,
  input logic             rstN,
  input logic             ioReq,
  input logic [DW_AW-1:0] ioDwAddr,
  input logic             ioReady,
  input logic             ioHit,
  input logic             cfgReq,
  input logic [23:0]      cfgRoute,
  input logic [36:0]      cfgPayload,
  input logic             cfgAck
);
  // R6: request held until acknowledged
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && !cfgAck |=> cfgReq);

  // R4: request fields stable while pending
  p_req_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && !cfgAck |=> $stable(cfgRoute) && $stable(cfgPayload));

  // R6 / R7: acknowledge ends the request and completes a claimed access
  p_ack_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgReq && cfgAck |=> !cfgReq && ioReady && ioHit);

  // R4: a request only follows a data-window access
  p_req_origin_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgReq) |-> $past(ioReq) && ($past(ioDwAddr) == DATA_DW));

  // R8: completion is a single-cycle pulse
  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    ioReady |=> !ioReady);

  // R8: claim flag only alongside completion
  p_hit_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    ioHit |-> ioReady);
endmodule

bind cfg_port cfg_port_chk #(.DW_AW(DW_AW), .DATA_DW(DATA_DW)) u_chk (
  .clk(clk), .rstN(rstN), .ioReq(ioReq), .ioDwAddr(ioDwAddr),
  .ioReady(ioReady), .ioHit(ioHit), .cfgReq(cfgReq),
  .cfgRoute({cfgBus, cfgDev, cfgFunc, cfgReg, 2'b00}),
  .cfgPayload({cfgWrite, cfgBe, cfgWdata}),
  .cfgAck(cfgAck)
);

// File: tb/cfg_port_bench.sv
module cfg_port_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioReq = 1'b0, ioWrite = 1'b0;
  logic [13:0] ioDwAddr = '0;
  logic [3:0]  ioBe = '0;
  logic [31:0] ioWdata = '0;
  logic [31:0] ioRdata;
  logic        ioReady, ioHit, cfgReq, cfgWrite;
  logic [7:0]  cfgBus;
  logic [4:0]  cfgDev;
  logic [2:0]  cfgFunc;
  logic [5:0]  cfgReg;
  logic [3:0]  cfgBe;
  logic [31:0] cfgWdata;
  logic        cfgAck = 1'b0;
  logic [31:0] cfgRdata = '0;

  int checks = 0, fails = 0;
  int ackDelay = 0;
  int reqCount = 0;
  logic        lastWr;
  logic [3:0]  lastBe;
  logic [31:0] lastWd;
  logic [31:0] modelAddr = '0;   // reference copy of the address register
  bit          done = 1'b0;

  localparam logic [13:0] A_DW = 14'h33E;
  localparam logic [13:0] D_DW = 14'h33F;

  always #4 clk = ~clk;

  cfg_port u_cfg_port (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rspOf(input logic [31:0] a);
    return {a[23:16], a[15:11], a[10:8], a[7:2], 10'h2A5};
  endfunction

  // Target responder
  initial forever begin
    @(negedge clk);
    if (cfgReq && !cfgAck) begin
      reqCount++;
      lastWr = cfgWrite; lastBe = cfgBe; lastWd = cfgWdata;
      repeat (ackDelay) @(negedge clk);
      cfgRdata = {cfgBus, cfgDev, cfgFunc, cfgReg, 10'h2A5};
      cfgAck = 1'b1;
      @(negedge clk);
      cfgAck = 1'b0;
    end
  end

  // Per-clock comparison of outputs against the model (R4, R8)
  always @(negedge clk) if (rstN && !done) begin
    if (cfgReq)
      chk("R4 route", {cfgBus, cfgDev, cfgFunc, cfgReg}, modelAddr[23:2]);
    if (ioHit && !ioReady)
      chk("R8 hit without ready", 32'(ioHit), 32'(ioReady));
  end

  task automatic ioAccess(input logic wr, input logic [13:0] dw, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic hit, output int lat);
    @(negedge clk);
    ioReq = 1'b1; ioWrite = wr; ioDwAddr = dw; ioBe = be; ioWdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ioReady && lat < 60);
    rd = ioRdata; hit = ioHit;
    ioReq = 1'b0;
    if (wr && dw == A_DW && be == 4'hF) modelAddr = wd & 32'h80FF_FFFC;
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        hit;
    int          lat, cnt0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(ioReady), 0);
    chk("R1 cfgReq after reset", 32'(cfgReq), 0);
    ioAccess(0, A_DW, 4'hF, 0, rd, hit, lat);
    chk("R1 address reg after reset", rd, 0);
    chk("R1 hit", 32'(hit), 1);

    ioAccess(1, A_DW, 4'hF, 32'hFFFF_FFFF, rd, hit, lat);
    chk("R2 write claimed", 32'(hit), 1);
    chk("R8 latency addr write", lat, 1);
    ioAccess(0, A_DW, 4'hF, 0, rd, hit, lat);
    chk("R2 reserved read zero", rd, 32'h80FF_FFFC);
    chk("R8 latency addr read", lat, 1);

    ioAccess(1, A_DW, 4'h3, 32'h0, rd, hit, lat);
    chk("R3 narrow write unclaimed", 32'(hit), 0);
    ioAccess(0, A_DW, 4'h1, 0, rd, hit, lat);
    chk("R3 narrow read ones", rd, 32'hFFFF_FFFF);
    chk("R3 narrow read unclaimed", 32'(hit), 0);
    ioAccess(0, A_DW, 4'hF, 0, rd, hit, lat);
    chk("R3 register unchanged", rd, 32'h80FF_FFFC);

    ioAccess(1, A_DW, 4'hF, 32'h0012_3A08, rd, hit, lat);
    cnt0 = reqCount;
    ioAccess(0, D_DW, 4'hF, 0, rd, hit, lat);
    chk("R5 disabled read ones", rd, 32'hFFFF_FFFF);
    chk("R5 disabled unclaimed", 32'(hit), 0);
    chk("R8 latency unclaimed", lat, 1);
    ioAccess(1, D_DW, 4'hF, 32'h1234_5678, rd, hit, lat);
    chk("R5 no request issued", reqCount, cnt0);

    // bus 12, device 1D, function 5, register 2B, reserved bits set
    ioAccess(1, A_DW, 4'hF, 32'h9012_EDAF, rd, hit, lat);
    ioAccess(0, A_DW, 4'hF, 0, rd, hit, lat);
    chk("R2 stored fields", rd, 32'h8012_EDAC);
    ackDelay = 0; cnt0 = reqCount;
    ioAccess(0, D_DW, 4'hF, 0, rd, hit, lat);
    chk("R7 read data", rd, rspOf(modelAddr));
    chk("R7 read claimed", 32'(hit), 1);
    chk("R6 latency no wait", lat, 2);
    chk("R4 one request", reqCount, cnt0 + 1);
    chk("R4 read direction", 32'(lastWr), 0);
    chk("R4 full lanes", 32'(lastBe), 32'hF);

    ackDelay = 3;
    ioAccess(1, D_DW, 4'h4, 32'hDEAD_BEEF, rd, hit, lat);
    chk("R6 latency wait 3", lat, 5);
    chk("R4 write direction", 32'(lastWr), 1);
    chk("R4 byte lane", 32'(lastBe), 32'h4);
    chk("R4 write data", lastWd, 32'hDEAD_BEEF);
    chk("R4 write claimed", 32'(hit), 1);

    ioAccess(1, A_DW, 4'hF, 32'h8003_0104, rd, hit, lat);
    ackDelay = 5;
    ioAccess(0, D_DW, 4'h8, 0, rd, hit, lat);
    chk("R6 latency wait 5", lat, 7);
    chk("R7 read data 2", rd, rspOf(modelAddr));
    chk("R4 high lane", 32'(lastBe), 32'h8);

    cnt0 = reqCount;
    ioAccess(0, 14'h33D, 4'hF, 0, rd, hit, lat);
    chk("R9 other read ones", rd, 32'hFFFF_FFFF);
    chk("R9 other unclaimed", 32'(hit), 0);
    ioAccess(0, 14'h0020, 4'hF, 0, rd, hit, lat);
    chk("R9 far address unclaimed", 32'(hit), 0);
    chk("R9 no request", reqCount, cnt0);
    ioAccess(0, A_DW, 4'hF, 0, rd, hit, lat);
    chk("R2 final readback", rd, 32'h8003_0104);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule